// File: doc/BRIEF.md
# IO Page Table Address Translator

This block turns device DMA addresses into physical memory addresses. Software programs a 64-bit control word and a 64-bit table base word. Each word can be reached as one 64-bit access or as two 32-bit halves. A device presents one address at a time on a ready/valid request port. When translation is off, the address comes back unchanged with full access rights.

When translation is on, the block works out where the translation entry sits in memory. It uses the selected table granule (8K or 64K) and a 3-bit table-size code to find the entry. It then reads one 64-bit entry over a simple memory request/response port. The entry arrives big-endian. The block decodes it into a physical address, a page mask and read/write permissions, and presents the result for one cycle.

A fault is flagged for an unsupported table size or for an entry whose valid bit is clear. Only one translation is in flight at any time.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are 0. The control and base words read back as zero.
- R2: The control word sits at offset 0x00 and the base word at 0x08. A wide access (reg_wide=1) at the word offset reads or writes all 64 bits. A narrow access at the word offset reads or writes bits 63:32, using data bits 31:0. A narrow access at the word offset +4 reads or writes bits 31:0.
- R3: Offset 0x10 (flush) reads as zero. Writes to it change neither the control word nor the base word.
- R4: With control bit 0 (enable) clear, the result appears in the cycle after the request is accepted, and no memory request is made. The result has rsp_addr equal to the input address, rsp_mask 0x1FFF, both permissions set and rsp_fault 0.
- R5: With enable set and control bit 2 clear (8K granule), let c be the code in control bits 18:16. The entry address is base + 8 * addr[22+c:13].
- R6: With enable set and control bit 2 set (64K granule), codes 0 to 5 give the entry address base + 8 * addr[25+c:16].
- R7: With the 64K granule and code 6 or 7, no memory request is made. The result appears in the cycle after acceptance with rsp_fault 1, no permissions, rsp_addr 0 and rsp_mask 0.
- R8: The fetched entry is big-endian. mem_rsp_data bits 7:0 carry the byte at the lowest address, so the entry value is mem_rsp_data with its byte order reversed.
- R9: If entry bit 63 (valid) is clear, the result has rsp_fault 1, no permissions, rsp_addr 0 and rsp_mask 0.
- R10: For a valid entry, rsp_rd_ok is 1, and rsp_wr_ok equals entry bit 1 (writable).
- R11: For a valid entry with bit 61 (large page) set, rsp_addr is entry bits 40:16 placed at bits 40:16, joined with addr[15:0], and rsp_mask is 0xFFFF. With bit 61 clear, rsp_addr is entry bits 40:13 placed at bits 40:13, joined with addr[12:0], and rsp_mask is 0x1FFF.
- R12: The response appears in the cycle after mem_rsp_valid is sampled. rsp_valid lasts exactly one cycle. req_ready is 0 from acceptance until the cycle after the response. mem_req_valid stays high with a stable address until mem_req_ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr/reg_wide |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | VA_W | Device address to translate |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Fetched entry present |
| mem_rsp_data | input | 64 | Fetched entry, lowest-address byte in bits 7:0 |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_addr | output | 64 | Translated address |
| rsp_mask | output | 16 | Page offset mask |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 1 | Translation fault |

## Verification
The bench builds the block with its defaults: a 32-bit device address and physical page bits up to bit 40. A 32-bit address is wide enough for the largest table sizes, the 1G range of 8K code 7 and the 2G range of 64K code 5. The bench can therefore check the index extraction at both ends of both granules. The tests also cover an entry whose page size differs from the table granule, and a fetch that stalls for several cycles before the memory accepts it.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
    localparam int WORD_W = 64;

    // control word fields
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_GRAN_BIT = 2;
    localparam int CTL_TSZ_LSB  = 16;

    // entry fields
    localparam int PTE_VALID_BIT = 63;
    localparam int PTE_BIG_BIT   = 61;
    localparam int PTE_WR_BIT    = 1;

    // register offsets
    localparam logic [4:0] OFS_CTL   = 5'h00;
    localparam logic [4:0] OFS_BASE  = 5'h08;
    localparam logic [4:0] OFS_FLUSH = 5'h10;

    localparam logic [15:0] MASK_SMALL = 16'h1FFF;
    localparam logic [15:0] MASK_LARGE = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } xl_state_e;
endpackage

// File: rtl/iopt_regs.sv
module iopt_regs
    import iopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic              wide,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              ctl_en,
    output logic              ctl_gran,
    output logic [2:0]        ctl_tsz,
    output logic [WORD_W-1:0] base
);
    localparam int NREG = 2;

    logic [WORD_W-1:0] regs_d [NREG];
    logic [WORD_W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en) begin
                if (wide && addr == 5'(i * 8)) begin
                    regs_d[i] = wdata;
                end else if (!wide && addr == 5'(i * 8)) begin
                    regs_d[i][63:32] = wdata[31:0];
                end else if (!wide && addr == 5'(i * 8 + 4)) begin
                    regs_d[i][31:0] = wdata[31:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (wide && addr == 5'(i * 8))
                rdata = regs_q[i];
            else if (!wide && addr == 5'(i * 8))
                rdata = {32'h0, regs_q[i][63:32]};
            else if (!wide && addr == 5'(i * 8 + 4))
                rdata = {32'h0, regs_q[i][31:0]};
        end
    end

    assign ctl_en   = regs_q[0][CTL_EN_BIT];
    assign ctl_gran = regs_q[0][CTL_GRAN_BIT];
    assign ctl_tsz  = regs_q[0][CTL_TSZ_LSB +: 3];
    assign base     = regs_q[1];
endmodule

// File: rtl/iopt_index.sv
module iopt_index
    import iopt_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0]   addr,
    input  logic              gran_large,
    input  logic [2:0]        tsz,
    output logic [WORD_W-1:0] offset,
    output logic              unsupported
);
    localparam int NCODE      = 8;
    localparam int NCODE_BIG  = 6;
    localparam int SMALL_BASE = 23;   // 8M covered by code 0
    localparam int LARGE_BASE = 26;   // 64M covered by code 0

    logic [WORD_W-1:0] off_small [NCODE];
    logic [WORD_W-1:0] off_large [NCODE];

    for (genvar c = 0; c < NCODE; c++) begin : g_code
        localparam int HI_S = (SMALL_BASE + c < VA_W) ? SMALL_BASE + c : VA_W;
        assign off_small[c] = WORD_W'(addr[HI_S-1:13]) << 3;
        if (c < NCODE_BIG) begin : g_big
            localparam int HI_L = (LARGE_BASE + c < VA_W) ? LARGE_BASE + c : VA_W;
            assign off_large[c] = WORD_W'(addr[HI_L-1:16]) << 3;
        end else begin : g_none
            assign off_large[c] = '0;
        end
    end

    always_comb begin
        offset      = gran_large ? off_large[tsz] : off_small[tsz];
        unsupported = gran_large && (int'(tsz) >= NCODE_BIG);
    end
endmodule

// File: rtl/iopt_swap.sv
module iopt_swap #(
    parameter int BYTES = 8
) (
    input  logic [BYTES*8-1:0] din,
    output logic [BYTES*8-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PHYS_HI = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic              reg_wide,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_addr,
    output logic [15:0]       rsp_mask,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok,
    output logic              rsp_fault
);
    localparam logic [WORD_W-1:0] PHYS_ALL = (WORD_W'(1) << (PHYS_HI + 1)) - 1;
    localparam logic [WORD_W-1:0] PG_SMALL = PHYS_ALL & ~WORD_W'(MASK_SMALL);
    localparam logic [WORD_W-1:0] PG_LARGE = PHYS_ALL & ~WORD_W'(MASK_LARGE);

    typedef struct packed {
        xl_state_e         state;
        logic [VA_W-1:0]   va;
        logic [WORD_W-1:0] ent_addr;
        logic [WORD_W-1:0] pa;
        logic [15:0]       mask;
        logic              rd;
        logic              wr;
        logic              fault;
    } xl_t;

    xl_t xl_d, xl_q;

    logic              ctl_en, ctl_gran;
    logic [2:0]        ctl_tsz;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] offset;
    logic              unsup;
    logic [WORD_W-1:0] pte;
    logic [WORD_W-1:0] va_ext;

    iopt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wide     (reg_wide),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctl_en   (ctl_en),
        .ctl_gran (ctl_gran),
        .ctl_tsz  (ctl_tsz),
        .base     (base)
    );

    iopt_index #(.VA_W(VA_W)) u_index (
        .addr        (req_addr),
        .gran_large  (ctl_gran),
        .tsz         (ctl_tsz),
        .offset      (offset),
        .unsupported (unsup)
    );

    iopt_swap #(.BYTES(WORD_W / 8)) u_swap (
        .din  (mem_rsp_data),
        .dout (pte)
    );

    assign va_ext = WORD_W'(xl_q.va);

    always_comb begin
        xl_d = xl_q;
        unique case (xl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    xl_d.va = req_addr;
                    if (!ctl_en) begin
                        xl_d.pa    = WORD_W'(req_addr);
                        xl_d.mask  = MASK_SMALL;
                        xl_d.rd    = 1'b1;
                        xl_d.wr    = 1'b1;
                        xl_d.fault = 1'b0;
                        xl_d.state = ST_DONE;
                    end else if (unsup) begin
                        xl_d.pa    = '0;
                        xl_d.mask  = '0;
                        xl_d.rd    = 1'b0;
                        xl_d.wr    = 1'b0;
                        xl_d.fault = 1'b1;
                        xl_d.state = ST_DONE;
                    end else begin
                        xl_d.ent_addr = base + offset;
                        xl_d.state    = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) xl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    xl_d.state = ST_DONE;
                    if (!pte[PTE_VALID_BIT]) begin
                        xl_d.pa    = '0;
                        xl_d.mask  = '0;
                        xl_d.rd    = 1'b0;
                        xl_d.wr    = 1'b0;
                        xl_d.fault = 1'b1;
                    end else begin
                        xl_d.rd    = 1'b1;
                        xl_d.wr    = pte[PTE_WR_BIT];
                        xl_d.fault = 1'b0;
                        if (pte[PTE_BIG_BIT]) begin
                            xl_d.pa   = (pte & PG_LARGE) | (va_ext & WORD_W'(MASK_LARGE));
                            xl_d.mask = MASK_LARGE;
                        end else begin
                            xl_d.pa   = (pte & PG_SMALL) | (va_ext & WORD_W'(MASK_SMALL));
                            xl_d.mask = MASK_SMALL;
                        end
                    end
                end
            end
            default: xl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xl_q <= '{state: ST_IDLE, default: '0};
        else        xl_q <= xl_d;
    end

    assign req_ready     = (xl_q.state == ST_IDLE);
    assign mem_req_valid = (xl_q.state == ST_FETCH);
    assign mem_req_addr  = xl_q.ent_addr;
    assign rsp_valid     = (xl_q.state == ST_DONE);
    assign rsp_addr      = xl_q.pa;
    assign rsp_mask      = xl_q.mask;
    assign rsp_rd_ok     = xl_q.rd;
    assign rsp_wr_ok     = xl_q.wr;
    assign rsp_fault     = xl_q.fault;
endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        rsp_valid,
    input logic [15:0] rsp_mask,
    input logic        rsp_rd_ok,
    input logic        rsp_wr_ok,
    input logic        rsp_fault
);
    // R12
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R12
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    // R12
    fetch_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid && req_ready));

    // R7
    fault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_rd_ok && !rsp_wr_ok && rsp_mask == 16'h0);

    // R10
    write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_wr_ok |-> rsp_rd_ok);

    // R11
    mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> (rsp_mask == 16'h1FFF || rsp_mask == 16'hFFFF));
endmodule

bind iopt_xlate iopt_xlate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_mask      (rsp_mask),
    .rsp_rd_ok     (rsp_rd_ok),
    .rsp_wr_ok     (rsp_wr_ok),
    .rsp_fault     (rsp_fault)
);

// File: tb/iopt_xlate_test.sv
module iopt_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wide = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [15:0] rsp_mask;
    logic        rsp_rd_ok, rsp_wr_ok, rsp_fault;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [63:0] PG8  = 64'h0000_01FF_FFFF_E000;
    localparam logic [63:0] PG64 = 64'h0000_01FF_FFFF_0000;
    localparam logic [63:0] BASE = 64'h0000_0040_1230_0000;

    always #10 clk = ~clk;

    iopt_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wide(reg_wide),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory returns lowest-address byte in bits 7:0
    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    task automatic reg_write(input logic [4:0] a, input logic w, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wide = w; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [4:0] a, input logic w, input logic [63:0] exp,
                             input string req);
        @(negedge clk);
        reg_addr = a; reg_wide = w;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic set_ctl(input logic en, input logic big, input int code);
        reg_write(5'h00, 1'b1, (64'(code) << 16) | (64'(big) << 2) | 64'(en));
    endtask

    // request that completes without a memory fetch
    task automatic xlate_direct(input logic [31:0] va, input logic [63:0] exp_pa,
                                input logic [15:0] exp_mask, input logic exp_rd,
                                input logic exp_wr, input logic exp_fault, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " no fetch"}, 64'(mem_req_valid), 64'd0);
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({req, " addr"}, rsp_addr, exp_pa);
        check({req, " mask"}, 64'(rsp_mask), 64'(exp_mask));
        check({req, " perm"}, {62'd0, rsp_rd_ok, rsp_wr_ok}, {62'd0, exp_rd, exp_wr});
        check({req, " fault"}, 64'(rsp_fault), 64'(exp_fault));
        @(negedge clk);
        check("R12 rsp one cycle", 64'(rsp_valid), 64'd0);
        check("R12 ready again", 64'(req_ready), 64'd1);
    endtask

    // request that fetches an entry
    task automatic xlate_fetch(input logic [31:0] va, input logic [63:0] pte, input int stall,
                               input logic [63:0] exp_ea, input logic [63:0] exp_pa,
                               input logic [15:0] exp_mask, input logic exp_rd,
                               input logic exp_wr, input logic exp_fault, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 fetch issued", 64'(mem_req_valid), 64'd1);
        check("R12 busy", 64'(req_ready), 64'd0);
        check({req, " entry addr"}, mem_req_addr, exp_ea);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R12 fetch held", 64'(mem_req_valid), 64'd1);
            check("R12 fetch addr stable", mem_req_addr, exp_ea);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check("R12 fetch dropped", 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        check("R12 no early rsp", 64'(rsp_valid), 64'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = to_lanes(pte);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({req, " addr"}, rsp_addr, exp_pa);
        check({req, " mask"}, 64'(rsp_mask), 64'(exp_mask));
        check({req, " perm"}, {62'd0, rsp_rd_ok, rsp_wr_ok}, {62'd0, exp_rd, exp_wr});
        check({req, " fault"}, 64'(rsp_fault), 64'(exp_fault));
        check("R12 busy at rsp", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R12 rsp one cycle", 64'(rsp_valid), 64'd0);
        check("R12 ready again", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset;
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        reg_check(5'h00, 1'b1, 64'd0, "R1 ctl zero");
        reg_check(5'h08, 1'b1, 64'd0, "R1 base zero");
    endtask

    task automatic t_regs;
        reg_write(5'h00, 1'b1, 64'h1122_3344_5566_7788);
        reg_check(5'h00, 1'b1, 64'h1122_3344_5566_7788, "R2 ctl wide");
        reg_check(5'h00, 1'b0, 64'h0000_0000_1122_3344, "R2 ctl upper half");
        reg_check(5'h04, 1'b0, 64'h0000_0000_5566_7788, "R2 ctl lower half");
        reg_write(5'h0C, 1'b0, 64'hFFFF_FFFF_CAFE_F00D);
        reg_write(5'h08, 1'b0, 64'hFFFF_FFFF_0BAD_BEEF);
        reg_check(5'h08, 1'b1, 64'h0BAD_BEEF_CAFE_F00D, "R2 base from halves");
        reg_write(5'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_check(5'h10, 1'b1, 64'd0, "R3 flush reads zero");
        reg_check(5'h00, 1'b1, 64'h1122_3344_5566_7788, "R3 ctl untouched");
        reg_check(5'h08, 1'b1, 64'h0BAD_BEEF_CAFE_F00D, "R3 base untouched");
    endtask

    task automatic t_pass;
        set_ctl(1'b0, 1'b1, 7);
        xlate_direct(32'h9234_5678, 64'h9234_5678, 16'h1FFF, 1'b1, 1'b1, 1'b0, "R4 passthrough");
    endtask

    task automatic t_small;
        logic [31:0] va;
        logic [63:0] pte;
        reg_write(5'h08, 1'b1, BASE);
        for (int c = 0; c < 8; c += 7) begin
            set_ctl(1'b1, 1'b0, c);
            va  = 32'hD2F5_A123;
            pte = 64'h8000_0000_0000_0002 | 64'h0000_00AB_CDEF_6000;
            xlate_fetch(va, pte, 0,
                        BASE + ((64'(va) >> 13) & ((64'd1 << (10 + c)) - 1)) * 8,
                        (pte & PG8) | 64'(va[12:0]), 16'h1FFF, 1'b1, 1'b1, 1'b0,
                        (c == 0) ? "R5 R8 R10 R11 small code0" : "R5 R8 R10 R11 small code7");
        end
    endtask

    task automatic t_large;
        logic [31:0] va;
        logic [63:0] pte;
        for (int c = 0; c < 6; c += 5) begin
            set_ctl(1'b1, 1'b1, c);
            va  = 32'hF7E5_4321;
            pte = 64'hA000_0000_0000_0000 | 64'h0000_0123_4567_0000;
            xlate_fetch(va, pte, 3,
                        BASE + ((64'(va) >> 16) & ((64'd1 << (10 + c)) - 1)) * 8,
                        (pte & PG64) | 64'(va[15:0]), 16'hFFFF, 1'b1, 1'b0, 1'b0,
                        (c == 0) ? "R6 R10 R11 large code0" : "R6 R10 R11 large code5");
        end
    endtask

    task automatic t_mixed;
        logic [31:0] va;
        logic [63:0] pte;
        // small table granule, entry marks a large page
        set_ctl(1'b1, 1'b0, 2);
        va  = 32'h0123_ABCD;
        pte = 64'hA000_0000_0000_0002 | 64'h0000_0155_5555_E000;
        xlate_fetch(va, pte, 1,
                    BASE + ((64'(va) >> 13) & 64'hFFF) * 8,
                    (pte & PG64) | 64'(va[15:0]), 16'hFFFF, 1'b1, 1'b1, 1'b0,
                    "R11 large page in small table");
    endtask

    task automatic t_invalid;
        set_ctl(1'b1, 1'b0, 0);
        xlate_fetch(32'h0000_4000, 64'h2000_00FF_FFFF_E002, 0,
                    BASE + 64'h10, 64'd0, 16'h0, 1'b0, 1'b0, 1'b1, "R9 invalid entry");
    endtask

    task automatic t_unsup;
        for (int c = 6; c < 8; c++) begin
            set_ctl(1'b1, 1'b1, c);
            xlate_direct(32'h1234_5678, 64'd0, 16'h0, 1'b0, 1'b0, 1'b1, "R7 unsupported code");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_pass();
        t_small();
        t_large();
        t_mixed();
        t_invalid();
        t_unsup();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule